// File: doc/BRIEF.md
# Open-Collector Serial Packet Link

This block moves a short packet (a small source address followed by one data byte) across a single wired-AND line. The line rests high and can only be pulled low. The transmit half takes a parallel packet when its enable is high and sends it as a series of fixed-length bit periods. Every packet begins with a low start period and ends with a released stop period. Between them the payload bits go out most significant first: a 1 releases the line and a 0 pulls it low.

The receive half watches the resolved line level. It takes a high-to-low transition as the possible start of a packet. It confirms the start at the middle of that period, then takes one sample from the middle of each payload period. When the last bit has been sampled, it writes the address and data into its output registers in one step and marks the update with a single-cycle valid pulse. Polling of senders and routing of received packets by address are left to the surrounding logic. The `bus_ext_n` input models every other driver on the same wire.

Top module: `oc_serial_link`

## Requirements
- R1: The resolved line `bus_line` equals `bus_ext_n` AND NOT `bus_pull`. `bus_pull` is 0 whenever the transmitter is idle, so an idle line reads 1 unless another driver holds it low.
- R2: An idle transmitter accepts `tx_addr`/`tx_data` on a clock edge where `tx_en` is 1, and `tx_busy` rises in the next cycle. While `tx_busy` is 1, `tx_en` is ignored and the packet already in flight is unchanged.
- R3: Each period lasts BIT_CYC cycles (default 8). In the cycles after acceptance, the line carries one low start period. Next come the ADDR_W address bits, then the DATA_W data bits, each MSB first, with a 1 released (line high) and a 0 pulled (line low). Last comes one released stop period.
- R4: `tx_done` is 1 for exactly one cycle: the first cycle after the stop period ends, which is cycle BIT_CYC*(ADDR_W+DATA_W+2)+1 after acceptance (97 by default). `tx_busy` reads 0 in that same cycle.
- R5: An idle, enabled receiver starts a packet on a high-to-low transition of the line. From that transition it counts cycles and samples each period at count BIT_CYC/2. This holds for any sender, local or external.
- R6: If the line is high again at the middle of the start period, the receiver drops the packet: `rx_valid` stays 0 and the outputs keep their values.
- R7: After the last payload bit has been sampled, `rx_addr`/`rx_data` take the packet and `rx_valid` is 1 for one cycle. For a local transmission, this is cycle BIT_CYC*(ADDR_W+DATA_W)+BIT_CYC/2+2 after acceptance (86 by default).
- R8: While `rx_en` is 0, the receiver ignores the line and returns to idle. `rx_valid` stays 0 and `rx_addr`/`rx_data` are not updated.
- R9: `rx_addr` and `rx_data` change only in a cycle where `rx_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Request to send the presented packet |
| tx_addr | input | ADDR_W | Source address to send |
| tx_data | input | DATA_W | Data byte to send |
| tx_busy | output | 1 | Transmitter is sending a packet |
| tx_done | output | 1 | One-cycle pulse after the stop period |
| bus_ext_n | input | 1 | Other drivers on the wire, 0 = pulling low |
| bus_pull | output | 1 | Local transmitter pulls the wire low |
| bus_line | output | 1 | Resolved wired-AND line level |
| rx_en | input | 1 | Receiver enable |
| rx_addr | output | ADDR_W | Last received address |
| rx_data | output | DATA_W | Last received data |
| rx_valid | output | 1 | One-cycle pulse when a packet is loaded |

## Verification
The assertions check properties that hold on every cycle. An idle transmitter never pulls the line, and a packet always opens with a pull. `tx_done` and `rx_valid` are single-cycle pulses, and `tx_done` coincides with the fall of `tx_busy`. The receive outputs move only alongside `rx_valid`, the receiver leaves idle only on a real falling edge, and a disabled receiver is always idle. Only the bench's scenarios can show the rest: the exact line level at the midpoint of each period, the end-to-end arrival of every data value, the exact cycles of `tx_done` and `rx_valid`, the rejection of short low glitches, the handling of a packet from an external sender, and the holding of the outputs while the receiver is disabled.

// File: rtl/oc_link_pkg.sv
package oc_link_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2
  } rx_state_e;

  // Periods on the wire per packet: start, payload bits, stop.
  function automatic int frame_periods(input int pkt_w);
    return pkt_w + 2;
  endfunction

  // Count within a period at which the receiver samples.
  function automatic int mid_count(input int bit_cyc);
    return bit_cyc / 2;
  endfunction

endpackage

// File: rtl/oc_link_tx.sv
module oc_link_tx #(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  parameter int BIT_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pull,
  output logic              tx_busy,
  output logic              tx_done
);
  localparam int PKT_W = ADDR_W + DATA_W;
  localparam int LAST  = oc_link_pkg::frame_periods(PKT_W) - 1;
  localparam int CNT_W = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam int IDX_W = $clog2(LAST + 1);

  logic             active;
  logic             done_q;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [PKT_W-1:0] shreg;

  // Named internal events.
  logic bit_end;
  logic in_start;
  logic in_payload;
  assign bit_end    = active && (cnt == CNT_W'(BIT_CYC - 1));
  assign in_start   = active && (idx == '0);
  assign in_payload = active && (idx != '0) && (idx <= IDX_W'(PKT_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
      idx    <= '0;
      shreg  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (tx_en) begin
          active <= 1'b1;
          shreg  <= {tx_addr, tx_data};
          cnt    <= '0;
          idx    <= '0;
        end
      end else if (bit_end) begin
        cnt <= '0;
        if (idx == IDX_W'(LAST)) begin
          active <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
          if (idx != '0) shreg <= {shreg[PKT_W-2:0], 1'b0};
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign tx_pull = in_start || (in_payload && !shreg[PKT_W-1]);
  assign tx_busy = active;
  assign tx_done = done_q;

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !tx_pull) else $error("idle transmitter pulls line");
  p_start_pulls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> tx_pull) else $error("packet does not open with start");
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done) else $error("done longer than one cycle");
  p_done_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> tx_done) else $error("busy fell without done");

endmodule

// File: rtl/oc_link_rx.sv
module oc_link_rx #(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  parameter int BIT_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              bus_in,
  output logic [ADDR_W-1:0] rx_addr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  import oc_link_pkg::*;

  localparam int PKT_W = ADDR_W + DATA_W;
  localparam int CNT_W = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam int IDX_W = $clog2(PKT_W);
  localparam int MID   = mid_count(BIT_CYC);

  rx_state_e        st;
  logic             line_d;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [PKT_W-2:0] shreg;
  logic             valid_q;

  // Named internal events.
  logic fall_seen;
  logic at_mid;
  logic period_end;
  logic last_bit;
  logic [PKT_W-1:0] full_pkt;
  assign fall_seen  = rx_en && line_d && !bus_in;
  assign at_mid     = (cnt == CNT_W'(MID));
  assign period_end = (cnt == CNT_W'(BIT_CYC - 1));
  assign last_bit   = (idx == IDX_W'(PKT_W - 1));
  assign full_pkt   = {shreg, bus_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_IDLE;
      line_d  <= 1'b1;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      valid_q <= 1'b0;
      rx_addr <= '0;
      rx_data <= '0;
    end else begin
      line_d  <= bus_in;
      valid_q <= 1'b0;
      if (st == RX_IDLE) begin
        if (fall_seen) begin
          st  <= RX_START;
          cnt <= CNT_W'(1);
        end
      end else if (!rx_en) begin
        st <= RX_IDLE;
      end else begin
        cnt <= period_end ? '0 : cnt + 1'b1;
        if (period_end && st == RX_START) begin
          st  <= RX_DATA;
          idx <= '0;
        end
        if (at_mid) begin
          if (st == RX_START) begin
            if (bus_in) st <= RX_IDLE;
          end else begin
            shreg <= full_pkt[PKT_W-2:0];
            if (last_bit) begin
              rx_addr <= full_pkt[PKT_W-1:DATA_W];
              rx_data <= full_pkt[DATA_W-1:0];
              valid_q <= 1'b1;
              st      <= RX_IDLE;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
      end
    end
  end

  assign rx_valid = valid_q;

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid) else $error("valid longer than one cycle");
  p_hold_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_addr) && $stable(rx_data))) else $error("outputs moved without valid");
  p_valid_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_en)) else $error("load while disabled");
  p_off_is_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (st == RX_IDLE)) else $error("disabled receiver not idle");
  p_start_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_IDLE && !(line_d && !bus_in)) |=> (st == RX_IDLE)) else $error("start without falling edge");

endmodule

// File: rtl/oc_serial_link.sv
module oc_serial_link #(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  parameter int BIT_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_busy,
  output logic              tx_done,
  input  logic              bus_ext_n,
  output logic              bus_pull,
  output logic              bus_line,
  input  logic              rx_en,
  output logic [ADDR_W-1:0] rx_addr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  logic pull_w;

  oc_link_tx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_CYC(BIT_CYC)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .tx_addr (tx_addr),
    .tx_data (tx_data),
    .tx_pull (pull_w),
    .tx_busy (tx_busy),
    .tx_done (tx_done)
  );

  // Wired-AND resolution: any driver pulling makes the line low.
  assign bus_pull = pull_w;
  assign bus_line = bus_ext_n & ~pull_w;

  oc_link_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_CYC(BIT_CYC)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .bus_in   (bus_line),
    .rx_addr  (rx_addr),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );

  p_wired_and_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ext_n || bus_pull) |-> !bus_line) else $error("line not pulled low");

endmodule

// File: tb/oc_serial_link_tb.sv
`timescale 1ns/1ps
module oc_serial_link_tb;
  localparam int AW  = 2;
  localparam int DW  = 8;
  localparam int BC  = 8;
  localparam int PW  = AW + DW;
  localparam int MID = BC / 2;
  localparam int RX_LAT   = BC * PW + MID + 2;
  localparam int DONE_LAT = BC * (PW + 2) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic [AW-1:0] tx_addr = '0;
  logic [DW-1:0] tx_data = '0;
  logic tx_busy, tx_done, bus_pull, bus_line, rx_valid;
  logic bus_ext_n = 1'b1;
  logic rx_en = 1'b1;
  logic [AW-1:0] rx_addr;
  logic [DW-1:0] rx_data;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  oc_serial_link #(.ADDR_W(AW), .DATA_W(DW), .BIT_CYC(BC)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_addr(tx_addr), .tx_data(tx_data),
    .tx_busy(tx_busy), .tx_done(tx_done), .bus_ext_n(bus_ext_n), .bus_pull(bus_pull),
    .bus_line(bus_line), .rx_en(rx_en), .rx_addr(rx_addr), .rx_data(rx_data),
    .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected line level in period j of a packet.
  function automatic logic wire_level(input logic [PW-1:0] pkt, input int j);
    if (j == 0) return 1'b0;
    if (j > PW) return 1'b1;
    return pkt[PW-j];
  endfunction

  task automatic run_frame(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit expect_rx, input bit poke);
    logic [PW-1:0] pkt;
    logic [AW-1:0] prev_a;
    logic [DW-1:0] prev_d;
    logic [AW-1:0] got_a;
    logic [DW-1:0] got_d;
    int vcount;
    int vcyc;
    pkt = {a, d};
    prev_a = rx_addr;
    prev_d = rx_data;
    got_a = '0;
    got_d = '0;
    vcount = 0;
    vcyc = -1;
    tx_en = 1'b1; tx_addr = a; tx_data = d;
    @(negedge clk);
    tx_en = 1'b0;
    for (int k = 1; k <= DONE_LAT + 1; k++) begin
      if (poke && k == 40) begin tx_en = 1'b1; tx_addr = ~a; tx_data = ~d; end
      if (poke && k == 41) tx_en = 1'b0;
      if (rx_valid) begin vcount++; vcyc = k; got_a = rx_addr; got_d = rx_data; end
      if (k == 1) chk(tx_busy == 1'b1, "R2 busy after accept", tx_busy, 1);
      if (k % BC == MID + 1 && k / BC <= PW + 1)
        chk(bus_line == wire_level(pkt, k / BC), "R3 line level at midpoint", bus_line,
            wire_level(pkt, k / BC));
      if (k == DONE_LAT - 1) chk(tx_busy && !tx_done, "R4 busy before done", {tx_busy, tx_done}, 2'b10);
      if (k == DONE_LAT) chk(!tx_busy && tx_done, "R4 done cycle", {tx_busy, tx_done}, 2'b01);
      if (k == DONE_LAT + 1) chk(!tx_done && !tx_busy, "R4 done one cycle", {tx_busy, tx_done}, 2'b00);
      @(negedge clk);
    end
    if (expect_rx) begin
      chk(vcount == 1 && vcyc == RX_LAT, "R7 valid pulse cycle", vcyc, RX_LAT);
      chk(got_a == a && got_d == d, poke ? "R2 busy ignores tx_en" : "R7 packet contents",
          {got_a, got_d}, {a, d});
    end else begin
      chk(vcount == 0, "R8 no valid while disabled", vcount, 0);
      chk(rx_addr == prev_a && rx_data == prev_d, "R8 outputs held", {rx_addr, rx_data},
          {prev_a, prev_d});
    end
  endtask

  task automatic bang_frame(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [PW-1:0] pkt;
    int vcount;
    logic [AW-1:0] got_a;
    logic [DW-1:0] got_d;
    pkt = {a, d};
    vcount = 0;
    got_a = '0;
    got_d = '0;
    for (int j = 0; j <= PW + 1; j++) begin
      for (int c = 0; c < BC; c++) begin
        bus_ext_n = wire_level(pkt, j);
        @(negedge clk);
        if (rx_valid) begin vcount++; got_a = rx_addr; got_d = rx_data; end
      end
    end
    bus_ext_n = 1'b1;
    chk(vcount == 1 && got_a == a && got_d == d, "R5 external sender received",
        {got_a, got_d}, {a, d});
  endtask

  task automatic glitch(input int width);
    logic [AW-1:0] pa;
    logic [DW-1:0] pd;
    int vcount;
    pa = rx_addr;
    pd = rx_data;
    vcount = 0;
    bus_ext_n = 1'b0;
    for (int c = 0; c < width; c++) @(negedge clk);
    bus_ext_n = 1'b1;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (rx_valid) vcount++;
    end
    chk(vcount == 0 && rx_addr == pa && rx_data == pd, "R6 short low rejected", vcount, 0);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_line == 1'b1 && bus_pull == 1'b0, "R1 idle line high", {bus_line, bus_pull}, 2'b10);
    chk(!tx_busy && !tx_done && !rx_valid, "R4 reset outputs quiet", {tx_busy, tx_done, rx_valid}, 0);
    chk(rx_addr == '0 && rx_data == '0, "R9 reset output values", {rx_addr, rx_data}, 0);

    bus_ext_n = 1'b0;
    @(negedge clk);
    chk(bus_line == 1'b0 && bus_pull == 1'b0, "R1 external pull", {bus_line, bus_pull}, 2'b00);
    bus_ext_n = 1'b1;
    repeat (BC) @(negedge clk);

    run_frame(2'd2, 8'hA5, 1'b1, 1'b0);
    run_frame(2'd1, 8'h3C, 1'b1, 1'b1);

    for (int i = 0; i < 256; i++)
      run_frame(AW'(i) ^ AW'(i >> 6), DW'(i), 1'b1, 1'b0);

    rx_en = 1'b0;
    run_frame(2'd3, 8'h81, 1'b0, 1'b0);
    rx_en = 1'b1;
    repeat (BC) @(negedge clk);

    bang_frame(2'd3, 8'h6E);
    for (int w = 1; w <= MID; w++) glitch(w);
    bang_frame(2'd0, 8'h01);
    run_frame(2'd1, 8'hFE, 1'b1, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule